// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block guards a small 8-bit controller against a hung program. A binary up counter advances on a slow, free-running oscillator clock. When the counter has taken a fixed number of active ticks (8192 by default), it raises a one-cycle reset request for the whole controller. The counter then starts again from zero. At 16 kHz that interval is 512 ms, and at 32 kHz it is 256 ms.

Software keeps the controller alive by writing one key byte (0x5A) to a write-only clear register at bus address 0xCC. The write happens in the bus clock domain. It is carried into the slow domain by a toggle handshake. The clear stays pending, and is visible on `clr_pending`, until the slow side returns an acknowledge.

A two-bit mode input selects one of three behaviours:
- off: the counter is held at zero.
- gated: the counter runs only in the full-speed and slow power states, and keeps its value in the two sleep states.
- always running: the counter runs in every power state.

The mode and power-state inputs are expected to be synchronous to the slow clock.

Top module: `kwdt_top`

## Requirements
- R1: While either reset is asserted, `wdt_rst_req` and `clr_pending` are low and the counter is zero. After the slow reset is released, the first request comes after exactly OVF_TICKS active ticks.
- R2: The request `wdt_rst_req` is a one-cycle pulse in the slow domain. It is raised on the tick that moves the counter from OVF_TICKS-1 back to zero.
- R3: After a request pulse, the counter restarts from zero. The next pulse follows after exactly OVF_TICKS further active ticks.
- R4: A bus write with `bus_wr`=1, `bus_addr`=0xCC and `bus_wdata`=0x5A restarts the counter from zero. The clear takes effect within a few slow-clock cycles. The next pulse then falls between OVF_TICKS and OVF_TICKS+8 slow ticks after the write.
- R5: A write of any other data to 0xCC, or of 0x5A to any other address, does not change the count and does not start a clear.
- R6: A read (`bus_rd`=1) of 0xCC returns 0x00 on `bus_rdata` in the next bus cycle. It neither clears the counter nor starts a clear.
- R7: With `wdt_mode`=00 (off), the counter is held at zero and no request is raised. Switching to another mode starts counting from zero.
- R8: With `wdt_mode`=01 (gated), the counter advances when `pwr_state` is 00 (full speed) or 01 (slow). It holds its value when `pwr_state` is 10 (idle) or 11 (sleep), and resumes from the held value.
- R9: With `wdt_mode`=10 or 11 (always running), the counter advances on every slow tick, whatever the value of `pwr_state`.
- R10: `clr_pending` rises in the bus cycle after a key write. It falls once the slow domain has acknowledged the clear. A key write made while a clear is already pending is merged into that clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | CPU bus clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of bus_clk |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; the clear register always reads as zero |
| clr_pending | output | 1 | High while a key clear is in flight to the slow domain |
| lo_clk | input | 1 | Slow oscillator clock that drives the counter |
| lo_rst_n | input | 1 | Active-low reset, slow domain |
| wdt_mode | input | 2 | 00 off, 01 gated, 10/11 always running |
| pwr_state | input | 2 | 00 full speed, 01 slow, 10 idle, 11 sleep |
| wdt_rst_req | output | 1 | One-cycle controller reset request |

## Verification
The counter can only be seen through the timing of `wdt_rst_req`. Any error in its state shows up as a pulse that arrives early or late, or does not arrive. Whether the key write was taken shows up on `clr_pending` within one bus cycle. A count that is off by one, a missed freeze or a lost clear shifts the next pulse by a known number of slow ticks. The bench therefore measures each pulse against the slow-clock edge count and expects an exact value, or a window of a few ticks where the clock crossing is involved. A stuck or stretched request is visible in the slow cycle that follows the pulse.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [1:0] {
    WM_OFF    = 2'b00,
    WM_GATED  = 2'b01,
    WM_ALWAYS = 2'b10,
    WM_ALT    = 2'b11
  } wdt_mode_e;

  typedef enum logic [1:0] {
    PS_FULL  = 2'b00,
    PS_SLOW  = 2'b01,
    PS_IDLE  = 2'b10,
    PS_SLEEP = 2'b11
  } pwr_state_e;

  // Decide whether a slow tick advances the counter.
  function automatic logic tick_allowed(input logic [1:0] mode,
                                        input logic [1:0] pwr);
    logic ok;
    unique case (mode)
      WM_OFF:    ok = 1'b0;
      WM_GATED:  ok = (pwr == PS_FULL) || (pwr == PS_SLOW);
      default:   ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/kwdt_bus_side.sv
module kwdt_bus_side #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter logic [7:0]      CLR_ADDR    = 8'hCC,
  parameter logic [7:0]      CLR_KEY     = 8'h5A,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output logic              pending,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] ADDR_MATCH = ADDR_W'(CLR_ADDR);
  localparam logic [DATA_W-1:0] KEY_MATCH  = DATA_W'(CLR_KEY);

  logic ack_s;
  logic key_hit;
  logic req_q;
  logic [DATA_W-1:0] rdata_q;

  kwdt_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  assign key_hit = wr && (addr == ADDR_MATCH) && (wdata == KEY_MATCH);
  assign pending = req_q ^ ack_s;

  // A key write while a clear is in flight merges into it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    req_q <= 1'b0;
    else if (key_hit && !pending)  req_q <= ~req_q;
  end

  // The clear register is write-only and reads back as zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= '0;
  end

  assign req_tgl = req_q;
  assign rdata   = rdata_q;

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int OVF_TICKS   = 8192,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(OVF_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl,
  input  logic [1:0]       mode,
  input  logic [1:0]       pwr,
  output logic             ack_tgl,
  output logic             ovf_pulse,
  output logic [CNT_W-1:0] cnt,
  output logic             clr_hit
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVF_TICKS - 1);

  logic             req_s;
  logic             seen_q;
  logic             run;
  logic             off;
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  kwdt_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tgl),
    .q     (req_s)
  );

  // The edge detector register doubles as the acknowledge toggle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= req_s;
  end

  assign clr_hit = req_s ^ seen_q;
  assign run     = tick_allowed(mode, pwr);
  assign off     = (mode == WM_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (clr_hit || off) begin
        cnt_q <= '0;
      end else if (run) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ack_tgl   = seen_q;
  assign ovf_pulse = pulse_q;
  assign cnt       = cnt_q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] CLR_ADDR    = 8'hCC,
  parameter logic [7:0] CLR_KEY     = 8'h5A,
  parameter int         OVF_TICKS   = 8192,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clr_pending,
  input  logic              lo_clk,
  input  logic              lo_rst_n,
  input  logic [1:0]        wdt_mode,
  input  logic [1:0]        pwr_state,
  output logic              wdt_rst_req
);

  localparam int CNT_W = $clog2(OVF_TICKS);

  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] cnt_q;
  logic             clr_hit;

  kwdt_bus_side #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CLR_ADDR    (CLR_ADDR),
    .CLR_KEY     (CLR_KEY),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_bus (
    .clk     (bus_clk),
    .rst_n   (bus_rst_n),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .ack_tgl (ack_tgl),
    .req_tgl (req_tgl),
    .pending (clr_pending),
    .rdata   (bus_rdata)
  );

  kwdt_counter #(
    .OVF_TICKS   (OVF_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cnt (
    .clk       (lo_clk),
    .rst_n     (lo_rst_n),
    .req_tgl   (req_tgl),
    .mode      (wdt_mode),
    .pwr       (pwr_state),
    .ack_tgl   (ack_tgl),
    .ovf_pulse (wdt_rst_req),
    .cnt       (cnt_q),
    .clr_hit   (clr_hit)
  );

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int         CNT_W    = 13,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] CLR_ADDR = 8'hCC,
  parameter logic [7:0] CLR_KEY  = 8'h5A
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              clr_pending,
  input logic              lo_clk,
  input logic              lo_rst_n,
  input logic [1:0]        wdt_mode,
  input logic [1:0]        pwr_state,
  input logic              wdt_rst_req,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              clr_hit
);

  // R2
  pulse_single_chk: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  // R3
  restart_zero_chk: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    wdt_rst_req |-> (cnt_q == '0));

  // R4
  clear_zero_chk: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    $past(clr_hit) |-> (cnt_q == '0) && !wdt_rst_req);

  // R7
  off_quiet_chk: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    (wdt_mode == 2'b00 && $past(wdt_mode) == 2'b00) |-> (!wdt_rst_req && cnt_q == '0));

  // R8
  frozen_hold_chk: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    ($past(wdt_mode) == 2'b01 && $past(pwr_state[1]) && !$past(clr_hit))
      |-> ($stable(cnt_q) && !wdt_rst_req));

  // R10
  pending_rise_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(clr_pending) |-> $past(bus_wr && bus_addr == ADDR_W'(CLR_ADDR)
                                 && bus_wdata == DATA_W'(CLR_KEY)));

endmodule

bind kwdt_top kwdt_chk #(
  .CNT_W    (CNT_W),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CLR_ADDR (CLR_ADDR),
  .CLR_KEY  (CLR_KEY)
) u_chk (
  .bus_clk     (bus_clk),
  .bus_rst_n   (bus_rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .clr_pending (clr_pending),
  .lo_clk      (lo_clk),
  .lo_rst_n    (lo_rst_n),
  .wdt_mode    (wdt_mode),
  .pwr_state   (pwr_state),
  .wdt_rst_req (wdt_rst_req),
  .cnt_q       (cnt_q),
  .clr_hit     (clr_hit)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;

  localparam int OVF = 8192;

  logic       bus_clk = 1'b0;
  logic       lo_clk  = 1'b0;
  logic       bus_rst_n = 1'b0;
  logic       lo_rst_n  = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       clr_pending;
  logic [1:0] wdt_mode = 2'b01;
  logic [1:0] pwr_state = 2'b00;
  logic       wdt_rst_req;

  int n_checks = 0;
  int n_fails  = 0;
  int lo_edge  = 0;

  always #4 bus_clk = ~bus_clk;
  always #8 lo_clk  = ~lo_clk;
  always @(posedge lo_clk) lo_edge <= lo_edge + 1;

  kwdt_top dut (
    .bus_clk     (bus_clk),
    .bus_rst_n   (bus_rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .clr_pending (clr_pending),
    .lo_clk      (lo_clk),
    .lo_rst_n    (lo_rst_n),
    .wdt_mode    (wdt_mode),
    .pwr_state   (pwr_state),
    .wdt_rst_req (wdt_rst_req)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit in_window(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Wait on slow negedges for a request; returns the slow edge index or -1.
  task automatic wait_pulse(input int max_ticks, output int edge_at);
    edge_at = -1;
    for (int i = 0; i < max_ticks; i++) begin
      @(negedge lo_clk);
      if (wdt_rst_req) begin
        edge_at = lo_edge;
        break;
      end
    end
  endtask

  task automatic run_quiet(input int ticks, input string tag);
    int seen = 0;
    for (int i = 0; i < ticks; i++) begin
      @(negedge lo_clk);
      if (wdt_rst_req) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read_zero();
    @(negedge bus_clk);
    bus_rd = 1'b1; bus_addr = 8'hCC;
    @(negedge bus_clk);
    bus_rd = 1'b0;
    chk(bus_rdata == 8'h00, "R6 read data", bus_rdata, 0);
    chk(clr_pending == 1'b0, "R6 read starts no clear", clr_pending, 0);
  endtask

  task automatic noise_traffic(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a, d;
      if ($urandom % 2 == 0) begin
        a = 8'hCC;
        d = 8'($urandom);
        if (d == 8'h5A) d = 8'h5B;
      end else begin
        a = 8'($urandom);
        if (a == 8'hCC) a = 8'hCD;
        d = 8'h5A;
      end
      bus_write(a, d);
      @(negedge bus_clk);
      chk(clr_pending == 1'b0, "R5 non-key write ignored", clr_pending, 0);
      if (i % 5 == 0) bus_read_zero();
    end
  endtask

  initial begin
    repeat (190000) @(posedge bus_clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int rel, p, e, w, n;
    void'($urandom(32'd4242));

    repeat (4) @(negedge lo_clk);
    // R1: reset state
    chk(wdt_rst_req == 1'b0, "R1 request low in reset", wdt_rst_req, 0);
    chk(clr_pending == 1'b0, "R1 pending low in reset", clr_pending, 0);
    bus_rst_n = 1'b1;
    lo_rst_n  = 1'b1;
    rel = lo_edge;

    // R1/R2: first pulse exactly OVF ticks after release
    wait_pulse(OVF + 50, e);
    chk(e - rel == OVF, "R1 R2 first period", e - rel, OVF);
    @(negedge lo_clk);
    chk(wdt_rst_req == 1'b0, "R2 pulse one cycle", wdt_rst_req, 0);
    p = e;

    // R3/R5/R6: restart from zero, random non-key traffic and reads
    fork
      wait_pulse(OVF + 50, e);
      noise_traffic(60);
    join
    chk(e - p == OVF, "R3 R5 R6 period unchanged", e - p, OVF);
    p = e;

    // R4/R10: key clear part way through
    n = 1500 + int'($urandom % 3000);
    run_quiet(n, "R4 no early pulse");
    w = lo_edge;
    bus_write(8'hCC, 8'h5A);
    chk(clr_pending == 1'b1, "R10 pending after key", clr_pending, 1);
    bus_write(8'hCC, 8'h5A); // merged into the pending clear
    begin
      int waited = 0;
      while (clr_pending && waited < 60) begin
        @(negedge bus_clk);
        waited++;
      end
      chk(clr_pending == 1'b0, "R10 pending clears", clr_pending, 0);
    end
    wait_pulse(OVF + 50, e);
    chk(in_window(e - w, OVF, OVF + 8), "R4 delayed by clear", e - w, OVF + 4);
    p = e;

    // R8: gated mode freezes in idle and sleep, counts in slow
    run_quiet(2500, "R8 running part");
    pwr_state = 2'b10;
    run_quiet(1200, "R8 idle frozen");
    pwr_state = 2'b11;
    run_quiet(800, "R8 sleep frozen");
    pwr_state = 2'b01;
    wait_pulse(OVF + 50, e);
    chk(e - p == OVF + 2000, "R8 held value resumes", e - p, OVF + 2000);
    p = e;

    // R9: always running counts in sleep (mode 10) and idle (mode 11)
    wdt_mode = 2'b10; pwr_state = 2'b11;
    wait_pulse(OVF + 50, e);
    chk(e - p == OVF, "R9 mode 10 in sleep", e - p, OVF);
    p = e;
    wdt_mode = 2'b11; pwr_state = 2'b10;
    wait_pulse(OVF + 50, e);
    chk(e - p == OVF, "R9 mode 11 in idle", e - p, OVF);

    // R7: off holds zero; enabling starts from zero
    wdt_mode = 2'b00; pwr_state = 2'b00;
    run_quiet(3000, "R7 off no pulse");
    bus_write(8'hCC, 8'h5A);
    run_quiet(20, "R7 off after key");
    wdt_mode = 2'b01;
    w = lo_edge;
    wait_pulse(OVF + 50, e);
    chk(e - w == OVF, "R7 restart from zero", e - w, OVF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule